// File: doc/BRIEF.md
# LED Peak-Current Ramp Sequencer

This block owns the step index that sets the shared peak current of three LED channels. It accepts decoded register writes from a command decoder. A command can place the index at a value at once or force it to zero. It can also start a ramp that walks the index toward a stored target, one step at a time. Each step waits for a programmable number of millisecond ticks before the index moves.

Two target registers are kept, one for rising and one for falling ramps. The target register written most recently is the one a run command uses. The step-time write both stores the dwell and launches the ramp. The ramp length comes from the distance between the present index and the target, so no division is needed. The ramp stops on its own when the index equals the target. The millisecond tick and the mapping from index to analog current both come from outside this block.

Top module: `led_dim_seq`

## Requirements
- R1: After reset `level` is 0 and `busy` is 0.
- R2: A command with code 001 loads `cmd_data` into `level` on the next cycle, with no ramp. It clears `busy` and cancels any ramp in progress.
- R3: A command with code 000 sets `level` to 0 and clears `busy`, cancelling any ramp in progress. Later ticks leave `level` at 0.
- R4: With step-time field t (t > 0, weight 8 ms per unit, so 00011 is 24 ms), `level` moves by exactly one on the t*8-th `ms_tick` after the run command or after the previous step. It does not move on any earlier tick.
- R5: A ramp runs |start − target| steps and so lasts |start − target|*t*8 ticks. `busy` stays high while the ramp runs and falls in the cycle in which `level` reaches the target. After that, `level` holds.
- R6: Code 101 writes the rising target and code 110 writes the falling target. A run command (code 111, `cmd_data` = step time) ramps toward the target register written most recently. Only a run command raises `busy`.
- R7: Without a command, `level` changes by at most one per cycle and never leaves 0..31. A ramp reaching 0 or 31 stays there.
- R8: A run command during a ramp restarts the ramp from the present `level` toward the newly selected target. The dwell count starts over.
- R9: Codes 010, 011 and 100 have no effect on `level` or `busy`. Target writes (101, 110) made during a ramp do not alter that ramp.
- R10: A run command whose target equals `level`, or whose step time is 0, leaves `busy` low and sets `level` to the target on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Register select code |
| cmd_data | input | 5 | Five-bit command field |
| level | output | 5 | Current step index, 0 means no current |
| busy | output | 1 | High while a ramp is running |

## Verification
The bench builds the block with its default parameters: a 5-bit field and an 8-tick time unit. This puts the whole 0..31 index range and the longest dwell of 248 ticks within reach. Ticks are pulsed by the bench one at a time, so the cycle of each step is known exactly.

Random ramps between random start and end indices use small dwells. Directed cases cover the longest dwell, restarts part-way through a dwell, ramps ending at both ends of the range, and a zero step time.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

    typedef enum logic [2:0] {
        OP_OFF    = 3'd0,
        OP_PEAK   = 3'd1,
        OP_DUTY_A = 3'd2,
        OP_DUTY_B = 3'd3,
        OP_DUTY_C = 3'd4,
        OP_AIM_UP = 3'd5,
        OP_AIM_DN = 3'd6,
        OP_RUN    = 3'd7
    } op_e;

endpackage

// File: rtl/led_dim_cfg.sv
module led_dim_cfg
    import led_dim_pkg::*;
#(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  op_e                op,
    input  logic [FIELD_W-1:0] data,
    output logic               go,
    output logic [FIELD_W-1:0] go_aim,
    output logic               go_zero,
    output logic [FIELD_W-1:0] dwell_units
);

    typedef struct packed {
        logic [FIELD_W-1:0] aim_up;
        logic [FIELD_W-1:0] aim_dn;
        logic               pick_dn;
        logic [FIELD_W-1:0] units;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cmd_valid) begin
            case (op)
                OP_AIM_UP: begin
                    cfg_d.aim_up  = data;
                    cfg_d.pick_dn = 1'b0;
                end
                OP_AIM_DN: begin
                    cfg_d.aim_dn  = data;
                    cfg_d.pick_dn = 1'b1;
                end
                OP_RUN:  cfg_d.units = data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign go          = cmd_valid && (op == OP_RUN);
    assign go_aim      = cfg_q.pick_dn ? cfg_q.aim_dn : cfg_q.aim_up;
    assign go_zero     = (data == '0);
    assign dwell_units = cfg_q.units;

endmodule

// File: rtl/led_dim_timer.sv
module led_dim_timer #(
    parameter int FIELD_W = 5,
    parameter int UNIT_MS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               run,
    input  logic               tick,
    input  logic [FIELD_W-1:0] units,
    output logic               expire
);

    localparam int LIM_W = FIELD_W + $clog2(UNIT_MS) + 1;

    logic [LIM_W-1:0] cnt_d, cnt_q;
    logic [LIM_W-1:0] limit;
    logic             last;

    assign limit  = LIM_W'(units) * LIM_W'(UNIT_MS);
    assign last   = (cnt_q == limit - LIM_W'(1));
    assign expire = run && tick && last && !restart;

    always_comb begin
        cnt_d = cnt_q;
        if (restart || !run) cnt_d = '0;
        else if (tick)       cnt_d = last ? '0 : cnt_q + LIM_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/led_dim_ramp.sv
module led_dim_ramp #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               force_off,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    input  logic               go,
    input  logic [FIELD_W-1:0] go_aim,
    input  logic               go_zero,
    input  logic               step,
    output logic [FIELD_W-1:0] level,
    output logic               busy
);

    typedef struct packed {
        logic [FIELD_W-1:0] level;
        logic [FIELD_W-1:0] aim;
        logic               busy;
    } ramp_t;

    ramp_t st_d, st_q;
    logic [FIELD_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        nxt  = (st_q.aim > st_q.level) ? st_q.level + FIELD_W'(1)
                                       : st_q.level - FIELD_W'(1);
        if (force_off) begin
            st_d.level = '0;
            st_d.aim   = '0;
            st_d.busy  = 1'b0;
        end else if (load) begin
            st_d.level = load_val;
            st_d.aim   = load_val;
            st_d.busy  = 1'b0;
        end else if (go) begin
            st_d.aim = go_aim;
            if (go_zero || (go_aim == st_q.level)) begin
                st_d.level = go_aim;
                st_d.busy  = 1'b0;
            end else begin
                st_d.busy  = 1'b1;
            end
        end else if (st_q.busy && step) begin
            st_d.level = nxt;
            st_d.busy  = (nxt != st_q.aim);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign busy  = st_q.busy;

endmodule

// File: rtl/led_dim_seq.sv
module led_dim_seq
    import led_dim_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int UNIT_MS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic [FIELD_W-1:0] cmd_data,
    output logic [FIELD_W-1:0] level,
    output logic               busy
);

    op_e                op;
    logic               go;
    logic               go_zero;
    logic [FIELD_W-1:0] go_aim;
    logic [FIELD_W-1:0] units;
    logic               step;
    logic               force_off;
    logic               load;

    assign op        = op_e'(cmd_code);
    assign force_off = cmd_valid && (op == OP_OFF);
    assign load      = cmd_valid && (op == OP_PEAK);

    led_dim_cfg #(.FIELD_W(FIELD_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .op          (op),
        .data        (cmd_data),
        .go          (go),
        .go_aim      (go_aim),
        .go_zero     (go_zero),
        .dwell_units (units)
    );

    led_dim_timer #(.FIELD_W(FIELD_W), .UNIT_MS(UNIT_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go),
        .run     (busy),
        .tick    (ms_tick),
        .units   (units),
        .expire  (step)
    );

    led_dim_ramp #(.FIELD_W(FIELD_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (force_off),
        .load      (load),
        .load_val  (cmd_data),
        .go        (go),
        .go_aim    (go_aim),
        .go_zero   (go_zero),
        .step      (step),
        .level     (level),
        .busy      (busy)
    );

endmodule

// File: rtl/led_dim_seq_chk.sv
module led_dim_seq_chk #(
    parameter int FIELD_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ms_tick,
    input logic               cmd_valid,
    input logic [2:0]         cmd_code,
    input logic [FIELD_W-1:0] cmd_data,
    input logic [FIELD_W-1:0] level,
    input logic               busy
);

    logic [FIELD_W:0] lvl_x;
    assign lvl_x = {1'b0, level};

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1) |=> (level == $past(cmd_data) && !busy)); // R2

    AST_SHUTDOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd0) |=> (level == '0 && !busy)); // R3

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !cmd_valid) |=> $stable(level)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(level) && !busy)); // R5

    AST_BUSY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && $past(cmd_code) == 3'd7)); // R6

    AST_ONE_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (lvl_x == $past(lvl_x) || lvl_x == $past(lvl_x) + 1'b1
                        || lvl_x + 1'b1 == $past(lvl_x))); // R7

    AST_DUTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !ms_tick && (cmd_code == 3'd2 || cmd_code == 3'd3 || cmd_code == 3'd4))
        |=> ($stable(level) && $stable(busy))); // R9

endmodule

bind led_dim_seq led_dim_seq_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .level     (level),
    .busy      (busy)
);

// File: tb/led_dim_seq_tb.sv
`timescale 1ns/1ps
module led_dim_seq_tb;

    localparam int W    = 5;
    localparam int UNIT = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ms_tick = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_code = 3'd0;
    logic [W-1:0] cmd_data = '0;
    logic [W-1:0] level;
    logic         busy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    led_dim_seq #(.FIELD_W(W), .UNIT_MS(UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .level(level), .busy(busy)
    );

    function automatic int move_toward(int s, int g, int k);
        int d = (g > s) ? g - s : s - g;
        int m = (k < d) ? k : d;
        return (g > s) ? s + m : s - m;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic cmd(int code, int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'(code); cmd_data = W'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        chk("R1 level", level, 0);
        chk("R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level after release", level, 0);

        // R5 R4 R6: 5 -> 15 at 16 ms per step is 160 ticks
        cmd(1, 5);
        chk("R2 load", level, 5);
        cmd(5, 15);
        cmd(7, 2);
        chk("R6 busy raised", busy, 1);
        ticks(15);
        chk("R4 no step before dwell", level, 5);
        ticks(1);
        chk("R4 step on dwell", level, 6);
        ticks(143);
        chk("R5 one step left", level, 14);
        chk("R5 still busy", busy, 1);
        ticks(1);
        chk("R5 reached target", level, 15);
        chk("R5 busy dropped", busy, 0);
        ticks(40);
        chk("R5 holds", level, 15);

        // R6: latest target write wins (falling)
        cmd(5, 20);
        cmd(6, 3);
        cmd(7, 1);
        ticks(8);
        chk("R6 down direction", level, 14);
        ticks(3);
        // R8: restart mid-dwell toward new rising target
        cmd(5, 18);
        cmd(7, 1);
        ticks(7);
        chk("R8 dwell restarted", level, 14);
        ticks(1);
        chk("R8 new direction", level, 15);
        // R9: ignored codes and target writes mid-ramp
        cmd(2, 0);
        cmd(3, 31);
        cmd(4, 7);
        chk("R9 duty codes level", level, 15);
        chk("R9 duty codes busy", busy, 1);
        cmd(6, 0);
        ticks(8);
        chk("R9 ramp unchanged", level, 16);
        chk("R9 still busy", busy, 1);
        // R3: shutdown mid-ramp
        cmd(0, 21);
        chk("R3 level zero", level, 0);
        chk("R3 busy low", busy, 0);
        ticks(20);
        chk("R3 stays zero", level, 0);

        // R2: direct load cancels ramp
        cmd(5, 30);
        cmd(7, 1);
        ticks(8);
        chk("R2 ramp moving", level, 1);
        cmd(1, 9);
        chk("R2 direct value", level, 9);
        chk("R2 busy cleared", busy, 0);
        ticks(16);
        chk("R2 no further ramp", level, 9);

        // R10: target equal and zero time
        cmd(5, 9);
        cmd(7, 3);
        chk("R10 equal target busy", busy, 0);
        chk("R10 equal target level", level, 9);
        cmd(1, 2);
        cmd(5, 31);
        cmd(7, 0);
        chk("R10 zero time jump", level, 31);
        chk("R10 zero time busy", busy, 0);

        // R7: ramps ending at both ends of the range
        cmd(1, 29);
        cmd(7, 1);
        ticks(16);
        chk("R7 top reached", level, 31);
        ticks(24);
        chk("R7 top held", level, 31);
        cmd(1, 2);
        cmd(6, 0);
        cmd(7, 1);
        ticks(40);
        chk("R7 bottom held", level, 0);
        chk("R7 bottom busy", busy, 0);

        // R4: longest dwell, 31 units = 248 ticks
        cmd(5, 1);
        cmd(7, 31);
        ticks(247);
        chk("R4 long dwell before", level, 0);
        ticks(1);
        chk("R4 long dwell step", level, 1);

        // random ramps
        for (int n = 0; n < 24; n++) begin
            int s = int'($urandom % 32);
            int g = int'($urandom % 32);
            int t = 1 + int'($urandom % 3);
            int d = (g > s) ? g - s : s - g;
            bit dn = 1'($urandom % 2);
            cmd(1, s);
            if (dn) begin
                cmd(5, int'($urandom % 32));
                cmd(6, g);
            end else begin
                cmd(6, int'($urandom % 32));
                cmd(5, g);
            end
            cmd(7, t);
            for (int k = 1; k <= d; k++) begin
                ticks(t * UNIT);
                chk("R5 R7 random step", level, move_toward(s, g, k));
                chk("R5 random busy", busy, (k < d) ? 1 : 0);
            end
            ticks(t * UNIT);
            chk("R6 random end", level, g);
        end

        finish_run();
    end

endmodule